// File: doc/BRIEF.md
# Sampling Clock Tap Control Registers

This block is a small memory-mapped register file that sits beside the sampling-clock logic of a high-speed SD host. Software uses it to turn the tap delay on, to read how many taps the delay line offers, to choose the sampling tap and the data-capture position, to switch the receive path from the default clock to the tuned sampling clock, and to enable automatic retuning. The block drives these settings straight to the sampling logic through dedicated output pins.

The sampling logic reports a lost lock with a one-cycle error pulse. While automatic retuning is enabled, that pulse sets a sticky error flag. Software reads the flag from the retune status register and clears it by writing that register with the flag bit at zero. The enable ANDed with the flag drives a level interrupt request.

The register port is a plain single-cycle read/write interface. Each register sits at a fixed word offset, and its byte address is that offset shifted left by the `BUS_SHIFT` parameter (0, 1 or 2). This lets the block sit behind 16-, 32- or 64-bit register strides.

Top module: `samp_clk_regs`

## Requirements
- R1: After reset every writable bit is zero, so all control outputs and `irq_o` are low. The tap-count field still reads `TAP_NUM`.
- R2: A register is hit only when `addr_i` equals its word offset shifted left by `BUS_SHIFT`. The word offsets are: tap control 0x0, tap select 0x2, capture position 0x4, clock select 0x6, retune control 0x8, retune status 0xA. Any other address reads 0 and a write to it changes nothing.
- R3: Tap control register. Bit 0 is the tap enable, read/write, and drives `tap_en_o`. Bits 23:16 always read `TAP_NUM`, and writes to them are ignored. All other bits read 0.
- R4: Tap select register. Bits `TAP_W-1:0` are read/write and drive `tap_sel_o`. Upper bits read 0.
- R5: Capture position register. Bits `POS_W-1:0` are read/write and drive `cap_pos_o`. Upper bits read 0.
- R6: Clock select register bit 0 drives `clk_sel_o` (1 selects the tuned clock). Retune control register bit 0 drives `retune_en_o`. All other bits of both registers read 0.
- R7: A read returns its data on `rdata_o` after the clock edge where `rd_en_i` is high, and `rdata_o` holds when `rd_en_i` is low. A write is visible on the outputs after the edge where `wr_en_i` is high.
- R8: The error flag is bit 2 of the retune status register. An `err_pulse_i` sets it at the next edge only while `retune_en_o` is 1. Once set, it stays set until software clears it.
- R9: A write to the retune status register with bit 2 at zero clears the flag. A write with bit 2 at one leaves the flag unchanged. If an error pulse arrives in the same cycle as a clearing write, the flag ends up set.
- R10: `irq_o` is high exactly when `retune_en_o` and the error flag are both 1. Dropping the enable masks the interrupt without clearing the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | AW | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| err_pulse_i | input | 1 | Retune error pulse from the sampling logic |
| tap_en_o | output | 1 | Tap delay enable |
| tap_sel_o | output | TAP_W | Selected sampling tap |
| cap_pos_o | output | POS_W | Data capture position |
| clk_sel_o | output | 1 | 1 selects the tuned sampling clock |
| retune_en_o | output | 1 | Automatic retune enable |
| irq_o | output | 1 | Qualified retune error interrupt |

## Verification
Every result is due one edge after its cause:
- control outputs after the write edge;
- `rdata_o` after the read edge;
- the error flag after the pulse or clearing-write edge.

`irq_o` is combinational from registered state, so it follows in the same cycle as the flag. The bench drives each stimulus on a falling edge and samples on the next falling edge, which is half a period after the single rising edge that must update the state. An exhaustive sweep writes all-ones to every address and then reads back all six registers and the output pins against an arithmetic model of the address map.

// File: rtl/scc_pkg.sv
package scc_pkg;
  typedef enum logic [3:0] {
    W_TAPCTL = 4'h0,
    W_TAPSEL = 4'h2,
    W_CAPPOS = 4'h4,
    W_CLKSEL = 4'h6,
    W_RTCTL  = 4'h8,
    W_RTSTAT = 4'hA
  } scc_word_e;

  typedef struct packed {
    logic tapctl;
    logic tapsel;
    logic cappos;
    logic clksel;
    logic rtctl;
    logic rtstat;
  } scc_hit_t;

  localparam int ENA_BIT  = 0;
  localparam int CNT_LSB  = 16;
  localparam int CNT_W    = 8;
  localparam int ERR_BIT  = 2;
  localparam int DATA_W   = 32;
endpackage

// File: rtl/scc_addr_dec.sv
module scc_addr_dec
  import scc_pkg::*;
#(
  parameter int AW        = 12,
  parameter int BUS_SHIFT = 2
) (
  input  logic [AW-1:0] addr_i,
  output scc_hit_t      hit_o
);
  localparam int WORD_W = AW - BUS_SHIFT;

  logic              aligned;
  logic [WORD_W-1:0] word;

  generate
    if (BUS_SHIFT == 0) begin : g_noshift
      assign aligned = 1'b1;
    end else begin : g_shift
      assign aligned = (addr_i[BUS_SHIFT-1:0] == '0);
    end
  endgenerate

  assign word = addr_i[AW-1:BUS_SHIFT];

  always_comb begin
    hit_o        = '0;
    hit_o.tapctl = aligned && (word == WORD_W'(W_TAPCTL));
    hit_o.tapsel = aligned && (word == WORD_W'(W_TAPSEL));
    hit_o.cappos = aligned && (word == WORD_W'(W_CAPPOS));
    hit_o.clksel = aligned && (word == WORD_W'(W_CLKSEL));
    hit_o.rtctl  = aligned && (word == WORD_W'(W_RTCTL));
    hit_o.rtstat = aligned && (word == WORD_W'(W_RTSTAT));
  end
endmodule

// File: rtl/scc_ctrl_regs.sv
module scc_ctrl_regs
  import scc_pkg::*;
#(
  parameter int TAP_W = 8,
  parameter int POS_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  scc_hit_t          hit_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              tap_en_o,
  output logic [TAP_W-1:0]  tap_sel_o,
  output logic [POS_W-1:0]  cap_pos_o,
  output logic              clk_sel_o,
  output logic              retune_en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tap_en_o    <= 1'b0;
      tap_sel_o   <= '0;
      cap_pos_o   <= '0;
      clk_sel_o   <= 1'b0;
      retune_en_o <= 1'b0;
    end else if (wr_en_i) begin
      if (hit_i.tapctl) tap_en_o    <= wdata_i[ENA_BIT];
      if (hit_i.tapsel) tap_sel_o   <= wdata_i[TAP_W-1:0];
      if (hit_i.cappos) cap_pos_o   <= wdata_i[POS_W-1:0];
      if (hit_i.clksel) clk_sel_o   <= wdata_i[ENA_BIT];
      if (hit_i.rtctl)  retune_en_o <= wdata_i[ENA_BIT];
    end
  end
endmodule

// File: rtl/scc_retune_err.sv
module scc_retune_err (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/samp_clk_regs.sv
module samp_clk_regs
  import scc_pkg::*;
#(
  parameter int AW        = 12,
  parameter int BUS_SHIFT = 2,
  parameter int TAP_W     = 8,
  parameter int POS_W     = 8,
  parameter int TAP_NUM   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              err_pulse_i,
  output logic              tap_en_o,
  output logic [TAP_W-1:0]  tap_sel_o,
  output logic [POS_W-1:0]  cap_pos_o,
  output logic              clk_sel_o,
  output logic              retune_en_o,
  output logic              irq_o
);
  localparam logic [CNT_W-1:0] CNT_VAL = CNT_W'(TAP_NUM);

  scc_hit_t          hit;
  logic              err_flag_q;
  logic              err_set;
  logic              err_clr;
  logic [DATA_W-1:0] rd_mux;

  scc_addr_dec #(.AW(AW), .BUS_SHIFT(BUS_SHIFT)) u_dec (
    .addr_i (addr_i),
    .hit_o  (hit)
  );

  scc_ctrl_regs #(.TAP_W(TAP_W), .POS_W(POS_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .hit_i       (hit),
    .wdata_i     (wdata_i),
    .tap_en_o    (tap_en_o),
    .tap_sel_o   (tap_sel_o),
    .cap_pos_o   (cap_pos_o),
    .clk_sel_o   (clk_sel_o),
    .retune_en_o (retune_en_o)
  );

  assign err_set = err_pulse_i && retune_en_o;
  assign err_clr = wr_en_i && hit.rtstat && !wdata_i[ERR_BIT];

  scc_retune_err u_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (err_set),
    .clr_i  (err_clr),
    .flag_o (err_flag_q)
  );

  assign irq_o = retune_en_o && err_flag_q;

  always_comb begin
    rd_mux = '0;
    unique case (1'b1)
      hit.tapctl: begin
        rd_mux[ENA_BIT]                 = tap_en_o;
        rd_mux[CNT_LSB +: CNT_W]        = CNT_VAL;
      end
      hit.tapsel: rd_mux[TAP_W-1:0]    = tap_sel_o;
      hit.cappos: rd_mux[POS_W-1:0]    = cap_pos_o;
      hit.clksel: rd_mux[ENA_BIT]      = clk_sel_o;
      hit.rtctl:  rd_mux[ENA_BIT]      = retune_en_o;
      hit.rtstat: rd_mux[ERR_BIT]      = err_flag_q;
      default:    rd_mux               = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_mux;
  end
endmodule

// File: rtl/scc_regs_chk.sv
module scc_regs_chk #(
  parameter int AW        = 12,
  parameter int BUS_SHIFT = 2,
  parameter int TAP_NUM   = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic          rd_en_i,
  input logic [AW-1:0] addr_i,
  input logic [31:0]   wdata_i,
  input logic [31:0]   rdata_o,
  input logic          err_pulse_i,
  input logic          retune_en_o,
  input logic          irq_o,
  input logic          flag_i
);
  logic stat_wr_zero;
  logic ctl_rd;
  assign stat_wr_zero = wr_en_i && (addr_i == AW'(32'hA << BUS_SHIFT)) && !wdata_i[2];
  assign ctl_rd       = rd_en_i && (addr_i == '0);

  // R8
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_i && !stat_wr_zero |=> flag_i);

  // R8
  no_set_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_i && !(err_pulse_i && retune_en_o) |=> !flag_i);

  // R9
  set_beats_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_pulse_i && retune_en_o |=> flag_i);

  // R10
  irq_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !retune_en_o |-> !irq_o);

  // R7
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));

  // R3
  tap_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_rd |=> rdata_o[23:16] == 8'(TAP_NUM));
endmodule

bind samp_clk_regs scc_regs_chk #(.AW(AW), .BUS_SHIFT(BUS_SHIFT), .TAP_NUM(TAP_NUM)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .rd_en_i     (rd_en_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .err_pulse_i (err_pulse_i),
  .retune_en_o (retune_en_o),
  .irq_o       (irq_o),
  .flag_i      (err_flag_q)
);

// File: tb/samp_clk_regs_tb.sv
module samp_clk_regs_tb;
  localparam int AW = 8, BS = 1, TW = 4, PW = 4, TN = 8;

  logic clk = 0, rst_ni = 0;
  logic wr_en = 0, rd_en = 0, err_pulse = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic tap_en, clk_sel, rt_en, irq;
  logic [TW-1:0] tap_sel;
  logic [PW-1:0] cap_pos;
  int n_chk = 0, n_fail = 0;

  // model state
  logic m_en, m_cs, m_rt, m_flag;
  logic [TW-1:0] m_ts;
  logic [PW-1:0] m_cp;

  always #10 clk = ~clk;

  samp_clk_regs #(.AW(AW), .BUS_SHIFT(BS), .TAP_W(TW), .POS_W(PW), .TAP_NUM(TN)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .err_pulse_i(err_pulse), .tap_en_o(tap_en),
    .tap_sel_o(tap_sel), .cap_pos_o(cap_pos), .clk_sel_o(clk_sel),
    .retune_en_o(rt_en), .irq_o(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int word_of(int a);
    if ((a % (1 << BS)) != 0) return -1;
    return a >> BS;
  endfunction

  function automatic logic [31:0] exp_rd(int a);
    case (word_of(a))
      0:  return (32'(TN) << 16) | 32'(m_en);
      2:  return 32'(m_ts);
      4:  return 32'(m_cp);
      6:  return 32'(m_cs);
      8:  return 32'(m_rt);
      10: return 32'(m_flag) << 2;
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_wr(int a, logic [31:0] d);
    case (word_of(a))
      0:  m_en = d[0];
      2:  m_ts = d[TW-1:0];
      4:  m_cp = d[PW-1:0];
      6:  m_cs = d[0];
      8:  m_rt = d[0];
      10: if (!d[2]) m_flag = 1'b0;
      default: ;
    endcase
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = AW'(a); wdata = d;
    @(negedge clk); wr_en = 0;
    model_wr(a, d);
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = AW'(a);
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic pulse();
    @(negedge clk); err_pulse = 1;
    @(negedge clk); err_pulse = 0;
    if (m_rt) m_flag = 1'b1;
  endtask

  task automatic check_all(string req);
    logic [31:0] d;
    for (int w = 0; w <= 10; w += 2) begin
      rd(w << BS, d);
      chk(req, d, exp_rd(w << BS));
    end
    chk(req, {31'b0, tap_en}, {31'b0, m_en});
    chk(req, 32'(tap_sel), 32'(m_ts));
    chk(req, 32'(cap_pos), 32'(m_cp));
    chk(req, {31'b0, clk_sel}, {31'b0, m_cs});
    chk(req, {31'b0, rt_en}, {31'b0, m_rt});
    chk("R10", {31'b0, irq}, {31'b0, m_rt & m_flag});
  endtask

  initial begin
    #2000000;
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d, hold;
    {m_en, m_cs, m_rt, m_flag} = '0; m_ts = '0; m_cp = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R1 reset state
    check_all("R1");

    // R2 R3 R4 R5 R6: exhaustive address sweep with all-ones writes
    for (int a = 0; a < (1 << AW); a++) begin
      wr(a, 32'hFFFF_FFFF);
      check_all("R2");
      for (int w = 0; w <= 8; w += 2) wr(w << BS, 32'h0);
    end

    // R3 R4 R5 R6 patterns
    wr(0, 32'h00AA_0001); check_all("R3");
    wr(2 << BS, 32'hFFFF_FFF5); check_all("R4");
    wr(4 << BS, 32'h0000_000A); check_all("R5");
    wr(6 << BS, 32'h1); wr(8 << BS, 32'h0); check_all("R6");

    // R8 pulse ignored while retune disabled
    pulse(); check_all("R8");
    wr(8 << BS, 32'h1);
    pulse(); check_all("R8");
    repeat (4) @(negedge clk);
    check_all("R8");
    // R9 write with bit2=1 keeps flag, zero clears
    wr(10 << BS, 32'h4); check_all("R9");
    wr(10 << BS, 32'h0); check_all("R9");
    // R9 set beats same-cycle clear
    @(negedge clk); wr_en = 1; addr = AW'(10 << BS); wdata = 0; err_pulse = 1;
    @(negedge clk); wr_en = 0; err_pulse = 0; m_flag = 1'b1;
    check_all("R9");
    // R10 mask and unmask
    wr(8 << BS, 32'h0); check_all("R10");
    wr(8 << BS, 32'h1); check_all("R10");

    // R7 read latency and hold
    rd(2 << BS, d);
    hold = d;
    @(negedge clk); addr = AW'(0);
    @(negedge clk);
    chk("R7", rdata, hold);
    wr(2 << BS, 32'h3);
    chk("R7", 32'(tap_sel), 32'h3);
    chk("R7", rdata, hold);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule